// File: doc/BRIEF.md
# Ten-Operation Accumulator Datapath Core

This block is a very small processor datapath. It holds two 8-bit data registers: an accumulator and one general register. On each clock edge where the opcode strobe is high, it carries out one operation from a fixed set of ten. An operation is a load from the input bus, a move between the two registers, a store to the output bus, or an arithmetic or logic step that combines the accumulator with the general register.

There is no program memory, no program counter and no flag. The surrounding logic or a test sequencer presents one opcode per cycle. The memory operand is folded onto the ports: as a source it reads the input bus, and as a destination it writes the registered output bus. Every datapath function can therefore be set up and observed from the pins. This makes the core a convenient target for instruction-sequence tests of the datapath and of the opcode decoder.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, the accumulator, the general register and `dout` are cleared to zero and `dout_valid` is low.
- R2: Opcode 4'd1 and opcode 4'd6 each load the accumulator from `din`.
- R3: Opcode 4'd5 loads the general register from `din`. Opcode 4'd2 copies the accumulator into the general register.
- R4: Opcode 4'd3 stores the general register to `dout`, and opcode 4'd4 stores the accumulator to `dout`. `dout_valid` is high for exactly the cycle that follows each store edge.
- R5: `dout` keeps its last value on every edge that carries no store.
- R6: Opcode 4'd7 writes accumulator + general register, modulo 256, into the accumulator. No carry is kept.
- R7: Opcode 4'd8 writes accumulator OR general register into the accumulator. Opcode 4'd9 writes accumulator AND general register into the accumulator.
- R8: Opcode 4'd10 replaces the accumulator with its bitwise complement.
- R9: Codes 4'd0 and 4'd11 to 4'd15 change no state. Any code presented with `op_valid` low also changes no state.
- R10: The accumulator changes only on opcodes 1, 6, 7, 8, 9 and 10. The general register changes only on opcodes 2 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| op_valid | input | 1 | Opcode strobe; the opcode executes on an edge where this is high |
| opcode | input | 4 | Operation code, 1 to 10; other values are no-operations |
| din | input | 8 | Input data bus, the source operand for loads |
| dout | output | 8 | Registered output data bus |
| dout_valid | output | 1 | High for the one cycle after a store |

## Verification
The bound checker runs on every cycle. It checks that stores and only stores raise the output pulse, that `dout` holds between stores, and that the addition and complement results are correct. It also checks that each register stays unchanged on every opcode that does not name it, including undefined codes and idle cycles. The bench's scenarios are needed for the rest: the reset values, the value routing of the loads and moves, the OR and AND results, and the modulo-256 wrap, all seen through store sequences at the ports. The bench also shows that a load presented with the strobe low leaves no trace in later stores.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_LDA_IN  = 4'd1;
  localparam logic [OPW-1:0] OP_MOV_RA  = 4'd2;
  localparam logic [OPW-1:0] OP_ST_R    = 4'd3;
  localparam logic [OPW-1:0] OP_ST_A    = 4'd4;
  localparam logic [OPW-1:0] OP_LDR_IN  = 4'd5;
  localparam logic [OPW-1:0] OP_LDA_IN2 = 4'd6;
  localparam logic [OPW-1:0] OP_ADD     = 4'd7;
  localparam logic [OPW-1:0] OP_OR      = 4'd8;
  localparam logic [OPW-1:0] OP_AND     = 4'd9;
  localparam logic [OPW-1:0] OP_NOT     = 4'd10;

  typedef enum logic [2:0] {
    ASRC_HOLD, ASRC_IN, ASRC_ADD, ASRC_OR, ASRC_AND, ASRC_NOT
  } a_src_e;

  typedef enum logic [1:0] {
    RSRC_HOLD, RSRC_IN, RSRC_ACC
  } r_src_e;

  typedef enum logic [1:0] {
    OSRC_NONE, OSRC_REG, OSRC_ACC
  } o_src_e;

  typedef struct packed {
    a_src_e a_src;
    r_src_e r_src;
    o_src_e o_src;
  } ctl_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic           valid,
  input  logic [OPW-1:0] op,
  output ctl_t           ctl
);
  always_comb begin
    ctl = '{a_src: ASRC_HOLD, r_src: RSRC_HOLD, o_src: OSRC_NONE};
    if (valid) begin
      case (op)
        OP_LDA_IN, OP_LDA_IN2: ctl.a_src = ASRC_IN;
        OP_MOV_RA:             ctl.r_src = RSRC_ACC;
        OP_ST_R:               ctl.o_src = OSRC_REG;
        OP_ST_A:               ctl.o_src = OSRC_ACC;
        OP_LDR_IN:             ctl.r_src = RSRC_IN;
        OP_ADD:                ctl.a_src = ASRC_ADD;
        OP_OR:                 ctl.a_src = ASRC_OR;
        OP_AND:                ctl.a_src = ASRC_AND;
        OP_NOT:                ctl.a_src = ASRC_NOT;
        default:               ;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  a_src_e        sel,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] gpr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] y
);
  logic [DW-1:0] sum;

  assign sum = acc + gpr;

  always_comb begin
    case (sel)
      ASRC_IN:  y = din;
      ASRC_ADD: y = sum;
      ASRC_OR:  y = acc | gpr;
      ASRC_AND: y = acc & gpr;
      ASRC_NOT: y = ~acc;
      default:  y = acc;
    endcase
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] opcode,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  dout,
  output logic           dout_valid
);
  ctl_t          ctl;
  logic [DW-1:0] acc_q, reg_q;
  logic [DW-1:0] acc_d, reg_d, out_d;
  logic          acc_en, reg_en, out_en;

  acc_decode u_dec (
    .valid (op_valid),
    .op    (opcode),
    .ctl   (ctl)
  );

  acc_alu #(.DW(DW)) u_alu (
    .sel (ctl.a_src),
    .acc (acc_q),
    .gpr (reg_q),
    .din (din),
    .y   (acc_d)
  );

  always_comb begin
    acc_en = (ctl.a_src != ASRC_HOLD);
    reg_en = (ctl.r_src != RSRC_HOLD);
    out_en = (ctl.o_src != OSRC_NONE);
    reg_d  = (ctl.r_src == RSRC_IN) ? din : acc_q;
    out_d  = (ctl.o_src == OSRC_REG) ? reg_q : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= '0;
    else if (reg_en) reg_q <= reg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout <= '0;
    else if (out_en) dout <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_valid <= 1'b0;
    else        dout_valid <= out_en;
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [3:0]    opcode,
  input logic [DW-1:0] dout,
  input logic          dout_valid,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] reg_q
);
  logic is_store, a_touch, r_touch;
  assign is_store = op_valid && (opcode == 4'd3 || opcode == 4'd4);
  assign a_touch  = op_valid && (opcode == 4'd1 || opcode == 4'd6 ||
                    (opcode >= 4'd7 && opcode <= 4'd10));
  assign r_touch  = op_valid && (opcode == 4'd2 || opcode == 4'd5);

  p_store_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_store |=> dout_valid);
  p_no_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !is_store |=> !dout_valid);
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !is_store |=> $stable(dout));
  p_add_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 4'd7) |=>
      acc_q == DW'($past(acc_q) + $past(reg_q)));
  p_cpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 4'd10) |=> acc_q == ~$past(acc_q));
  p_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || opcode == 4'd0 || opcode > 4'd10) |=>
      ($stable(acc_q) && $stable(reg_q)));
  p_acc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !a_touch |=> $stable(acc_q));
  p_reg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !r_touch |=> $stable(reg_q));
endmodule

bind acc_core acc_core_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .opcode     (opcode),
  .dout       (dout),
  .dout_valid (dout_valid),
  .acc_q      (acc_q),
  .reg_q      (reg_q)
);

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] opcode;
  logic [7:0] din;
  logic [7:0] dout;
  logic       dout_valid;

  int n_vec = 0;
  int n_bad = 0;
  int ma = 0, mr = 0, mo = 0, mv = 0;

  always #2 clk = ~clk;

  acc_core u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .din(din), .dout(dout), .dout_valid(dout_valid)
  );

  task automatic check(input string tag);
    n_vec++;
    if (dout !== mo[7:0] || dout_valid !== mv[0]) begin
      n_bad++;
      $display("FAIL %s dout=%0d valid=%0d expected dout=%0d valid=%0d",
               tag, dout, dout_valid, mo, mv);
    end
  endtask

  task automatic step(input bit v, input int op, input int d, input string tag);
    op_valid = v;
    opcode   = 4'(op);
    din      = 8'(d);
    @(posedge clk);
    mv = 0;
    if (v) begin
      case (op)
        1, 6: ma = d & 255;
        2:    mr = ma;
        3:    begin mo = mr; mv = 1; end
        4:    begin mo = ma; mv = 1; end
        5:    mr = d & 255;
        7:    ma = (ma + mr) & 255;
        8:    ma = ma | mr;
        9:    ma = ma & mr;
        10:   ma = (~ma) & 255;
        default: ;
      endcase
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; opcode = '0; din = '0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    step(1, 4, 8'h5a, "R1 acc zero after reset");
    step(1, 3, 8'h5a, "R1 reg zero after reset");
    step(0, 0, 0,     "R4 pulse drops");
    step(1, 1, 8'h3c, "R2 load via 1");
    step(1, 4, 0,     "R2 store A");
    step(1, 6, 8'hc3, "R2 load via 6");
    step(1, 4, 0,     "R2 store A");
    step(1, 5, 8'h81, "R3 load R");
    step(1, 3, 0,     "R3 store R");
    step(1, 2, 8'h11, "R3 move A to R");
    step(1, 3, 0,     "R4 store R back-to-back");
    step(1, 0, 0,     "R5 dout holds");
    step(1, 12, 0,    "R5 dout holds");
    step(1, 1, 200,   "R6 setup A");
    step(1, 5, 100,   "R6 setup R");
    step(1, 7, 0,     "R6 add");
    step(1, 4, 0,     "R6 wrapped sum");
    step(1, 3, 0,     "R10 R unchanged by add");
    step(1, 1, 8'hf0, "R7 setup A");
    step(1, 5, 8'h3c, "R7 setup R");
    step(1, 8, 0,     "R7 or");
    step(1, 4, 0,     "R7 or result");
    step(1, 9, 0,     "R7 and");
    step(1, 4, 0,     "R7 and result");
    step(1, 10, 0,    "R8 complement");
    step(1, 4, 0,     "R8 complement result");
    step(1, 10, 0,    "R8 double complement");
    step(1, 4, 0,     "R8 restored");
    for (int k = 11; k <= 15; k++) step(1, k, 8'hee, "R9 undefined code");
    step(1, 0, 8'hee, "R9 code zero");
    step(0, 1, 8'h77, "R9 strobe low load A");
    step(0, 5, 8'h66, "R9 strobe low load R");
    step(1, 4, 0,     "R9 A untouched");
    step(1, 3, 0,     "R9 R untouched");
    step(1, 5, 8'h09, "R10 setup R");
    step(1, 1, 8'h50, "R10 load A only");
    step(1, 3, 0,     "R10 R kept");
    step(1, 4, 0,     "R10 A loaded");
    for (int k = 0; k < 6; k++) begin
      step(1, 7, 0, "R6 repeated add");
      step(1, 4, 0, "R6 repeated add result");
    end
    step(1, 0, 0, "R4 final pulse drop");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule